// File: doc/BRIEF.md
# Packet Command Decoder with Sense Tracking

This block interprets a finished 12-byte command packet, held stable by a neighbouring register array, and tells a transfer controller what to do next: start a read of a given length, report an error, or nothing further. While it does so it keeps the device status byte, the error byte and a 10-byte sense record up to date. Five commands are understood: a readiness probe, an identity query, a sense request, a spin-up and a sector read. Every other opcode is rejected as an invalid command.

Sector reads are handed to the media side over a request/acknowledge port. That port carries the start block, the block count and a decoded sector format, and returns a 16-bit status code and a byte length. The identity table and a snapshot of the sense record are exposed through a small byte read port. The transfer controller uses that port to fetch the data of identity and sense responses.

A completion is signalled by a one-cycle `done` pulse together with a response type and a 16-bit length. Packet byte k occupies `cmd_pkt[8k+7:8k]`, and sense byte k occupies `sense[8k+7:8k]`.

Top module: `pkt_cmd_decoder`

## Requirements
- R1: After reset, status is 0x50, error is 0x01, all sense bytes are 0, and `done`, `irq` and `med_req` are low.
- R2: Posting a result code r sets sense byte 0 to 0xF0, sense byte 2 to r[7:0] and sense byte 8 to r[15:8], and sets error to {r[3:0],4'h0}. A nonzero r sets status to 0x51 and pulses `irq` together with `done`. A zero r clears only status bits 7 and 0.
- R3: A `cmd_start` while no media request is open is accepted and sets status bit 7. For every command except a valid sector read, `done` is high for exactly the one cycle after the accepting edge. The response type encoding is 0 = none, 1 = read, 2 = error.
- R4: Opcode 0x00 (ready probe) with `medium_present` low posts result 0x3A02 and responds with an error. With a medium present it posts result 0, sets status to 0x50, pulses `irq` and responds with none.
- R5: Opcode 0x12 (identity) takes its offset from packet byte 2. An offset of 32 or more sets status to 0x51 and error to 0x05, leaves the sense bytes untouched and responds with an error. Otherwise it posts result 0 and responds with a read of min(byte 4, 32 - offset) bytes. Read-port address a then returns table byte offset+a, where table byte k is (37k + 11) mod 256, or 0 when offset+a is 32 or more.
- R6: Opcode 0x03 (sense request) posts result 0 and responds with a read of min(packet byte 4, 10) bytes. Read-port address a below 10 returns sense byte a as it stood before this command; higher addresses return 0.
- R7: Opcode 0x70 (spin-up) posts result 0, pulses `irq` and responds with none.
- R8: Opcode 0x30 (sector read) drives `med_lba` from packet bytes 2..4 and `med_count` from bytes 8..10, most significant byte first. The format code comes from packet byte 1: 0x20 and 0x28 give 0, 0x24 gives 1, 0x30 gives 2.
- R9: A sector read whose mode byte is any other value posts result 0x2405, responds with an error and raises no media request.
- R10: `med_req` rises on the edge after the sector read is accepted and stays high until the edge on which `med_ack` is sampled high, then falls. A zero `med_status` then posts result 0 and responds with a read of `med_len` bytes. A nonzero status posts it as the result, writes the block address into sense bytes 5, 6 and 7 (most significant first) and responds with an error. `done` is high for the cycle after that edge.
- R11: Any other opcode posts result 0x2005 and responds with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Packet complete, decode it |
| cmd_pkt | input | 96 | Packet bytes, byte k at bits 8k+7:8k |
| medium_present | input | 1 | A medium is loaded |
| med_req | output | 1 | Sector read request to media side |
| med_lba | output | 24 | Start block of the request |
| med_count | output | 24 | Number of blocks requested |
| med_fmt | output | 2 | Sector format: 0 mode-1, 1 extended, 2 raw |
| med_ack | input | 1 | Media side finished the request |
| med_status | input | 16 | Result code from media side |
| med_len | input | 16 | Byte length produced by media side |
| done | output | 1 | One-cycle completion pulse |
| resp_type | output | 2 | 0 none, 1 read, 2 error |
| resp_len | output | 16 | Byte length of a read response |
| irq | output | 1 | One-cycle interrupt pulse |
| status | output | 8 | Device status byte |
| error | output | 8 | Device error byte |
| sense | output | 80 | Sense record, byte k at bits 8k+7:8k |
| rd_addr | input | 5 | Response byte address |
| rd_data | output | 8 | Response byte at `rd_addr` |

## Verification
The assertions assume that `cmd_start` is a single-cycle pulse and that it never arrives while a response is still being signalled or a media request is open. They also assume that `med_ack` is only asserted while `med_req` is high and lasts one cycle. The bench issues each command as a one-cycle pulse and waits for `done` plus idle cycles before the next one. Its media responder raises the acknowledge for one cycle, only after seeing the request, after a chosen delay. Packet contents are held steady from the pulse until the response.

// File: rtl/pkt_dec_pkg.sv
package pkt_dec_pkg;
  localparam int PKT_BYTES   = 12;
  localparam int SENSE_BYTES = 10;
  localparam int ID_BYTES    = 32;
  localparam int LBA_W       = 24;
  localparam int LEN_W       = 16;
  localparam int RES_W       = 16;

  typedef enum logic [1:0] {RSP_NONE = 2'd0, RSP_READ = 2'd1, RSP_ERR = 2'd2} rsp_e;
  typedef enum logic [1:0] {FMT_M1 = 2'd0, FMT_EXT = 2'd1, FMT_RAW = 2'd2} fmt_e;
  typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_ID = 2'd1, SRC_SENSE = 2'd2} src_e;

  // error byte derived from a posted result
  function automatic logic [7:0] fold_err(input logic [RES_W-1:0] r);
    return {r[3:0], 4'h0};
  endfunction

  // identity table content, computed
  function automatic logic [7:0] id_byte(input logic [5:0] k);
    logic [7:0] t;
    t = {2'b00, k} * 8'd37 + 8'd11;
    return t;
  endfunction

  function automatic logic [7:0] clip_len(input logic [7:0] req, input logic [7:0] lim);
    return (req > lim) ? lim : req;
  endfunction
endpackage

// File: rtl/pkt_mode_decode.sv
module pkt_mode_decode import pkt_dec_pkg::*; (
  input  logic [7:0] mode_byte,
  output fmt_e       fmt,
  output logic       mode_ok
);
  always_comb begin
    mode_ok = 1'b1;
    fmt     = FMT_M1;
    case (mode_byte)
      8'h20, 8'h28: fmt = FMT_M1;
      8'h24:        fmt = FMT_EXT;
      8'h30:        fmt = FMT_RAW;
      default:      mode_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/pkt_id_rom.sv
module pkt_id_rom import pkt_dec_pkg::*; (
  input  logic [5:0] idx,
  output logic [7:0] val
);
  assign val = (idx < 6'(ID_BYTES)) ? id_byte(idx) : 8'h00;
endmodule

// File: rtl/pkt_sense_store.sv
module pkt_sense_store import pkt_dec_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_res,
  input  logic [RES_W-1:0]     res_val,
  input  logic                 set_lba,
  input  logic [LBA_W-1:0]     lba,
  input  logic                 take_snap,
  output logic [8*SENSE_BYTES-1:0] sense_flat,
  output logic [7:0]           snap [SENSE_BYTES]
);
  logic [7:0] sb [SENSE_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SENSE_BYTES; i++) begin
        sb[i]   <= 8'h00;
        snap[i] <= 8'h00;
      end
    end else begin
      if (take_snap)
        for (int i = 0; i < SENSE_BYTES; i++) snap[i] <= sb[i];
      if (set_res) begin
        sb[0] <= 8'hF0;
        sb[2] <= res_val[7:0];
        sb[8] <= res_val[15:8];
      end
      if (set_lba) begin
        sb[5] <= lba[23:16];
        sb[6] <= lba[15:8];
        sb[7] <= lba[7:0];
      end
    end
  end

  for (genvar g = 0; g < SENSE_BYTES; g++) begin : g_flat
    assign sense_flat[8*g +: 8] = sb[g];
  end
endmodule

// File: rtl/pkt_cmd_decoder.sv
module pkt_cmd_decoder import pkt_dec_pkg::*; #(
  parameter logic [7:0]  OP_READY     = 8'h00,
  parameter logic [7:0]  OP_IDENT     = 8'h12,
  parameter logic [7:0]  OP_SENSE     = 8'h03,
  parameter logic [7:0]  OP_SPIN      = 8'h70,
  parameter logic [7:0]  OP_READ      = 8'h30,
  parameter logic [15:0] RES_NODISC   = 16'h3A02,
  parameter logic [15:0] RES_BADFIELD = 16'h2405,
  parameter logic [15:0] RES_BADCMD   = 16'h2005
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic [95:0] cmd_pkt,
  input  logic        medium_present,
  output logic        med_req,
  output logic [23:0] med_lba,
  output logic [23:0] med_count,
  output logic [1:0]  med_fmt,
  input  logic        med_ack,
  input  logic [15:0] med_status,
  input  logic [15:0] med_len,
  output logic        done,
  output logic [1:0]  resp_type,
  output logic [15:0] resp_len,
  output logic        irq,
  output logic [7:0]  status,
  output logic [7:0]  error,
  output logic [79:0] sense,
  input  logic [4:0]  rd_addr,
  output logic [7:0]  rd_data
);
  logic [7:0] pb [PKT_BYTES];
  for (genvar g = 0; g < PKT_BYTES; g++) begin : g_pb
    assign pb[g] = cmd_pkt[8*g +: 8];
  end

  // named events for the checker
  logic accept, media_done;
  assign accept     = cmd_start && !med_req;
  assign media_done = med_req && med_ack;

  fmt_e dec_fmt;
  logic mode_ok;
  pkt_mode_decode u_mode (.mode_byte(pb[1]), .fmt(dec_fmt), .mode_ok(mode_ok));

  logic             set_res, set_lba, take_snap;
  logic [RES_W-1:0] res_val;
  logic [7:0]       snap [SENSE_BYTES];
  pkt_sense_store u_sense (
    .clk(clk), .rst_n(rst_n), .set_res(set_res), .res_val(res_val),
    .set_lba(set_lba), .lba(med_lba), .take_snap(take_snap),
    .sense_flat(sense), .snap(snap)
  );

  src_e       src_q;
  logic [4:0] base_q;
  logic [7:0] id_val;
  pkt_id_rom u_rom (.idx({1'b0, base_q} + {1'b0, rd_addr}), .val(id_val));

  // decode outcome
  logic             fin, raise, force_ready, raw_err, go_media;
  rsp_e             fin_rsp;
  logic [LEN_W-1:0] fin_len;
  src_e             fin_src;
  logic [4:0]       fin_base;

  always_comb begin
    set_res = 1'b0; res_val = '0; take_snap = 1'b0; set_lba = 1'b0;
    fin = 1'b0; fin_rsp = RSP_NONE; fin_len = '0; fin_src = SRC_NONE; fin_base = '0;
    raise = 1'b0; force_ready = 1'b0; raw_err = 1'b0; go_media = 1'b0;
    if (accept) begin
      case (pb[0])
        OP_READY: begin
          fin = 1'b1; set_res = 1'b1;
          if (!medium_present) begin
            res_val = RES_NODISC; fin_rsp = RSP_ERR;
          end else begin
            force_ready = 1'b1; raise = 1'b1;
          end
        end
        OP_IDENT: begin
          fin = 1'b1;
          if (pb[2] >= 8'(ID_BYTES)) begin
            raw_err = 1'b1; fin_rsp = RSP_ERR;
          end else begin
            set_res  = 1'b1; fin_rsp = RSP_READ; fin_src = SRC_ID;
            fin_base = pb[2][4:0];
            fin_len  = {8'h00, clip_len(pb[4], 8'(ID_BYTES) - pb[2])};
          end
        end
        OP_SENSE: begin
          fin = 1'b1; set_res = 1'b1; take_snap = 1'b1;
          fin_rsp = RSP_READ; fin_src = SRC_SENSE;
          fin_len = {8'h00, clip_len(pb[4], 8'(SENSE_BYTES))};
        end
        OP_SPIN: begin
          fin = 1'b1; set_res = 1'b1; raise = 1'b1;
        end
        OP_READ: begin
          if (mode_ok) go_media = 1'b1;
          else begin
            fin = 1'b1; set_res = 1'b1; res_val = RES_BADFIELD; fin_rsp = RSP_ERR;
          end
        end
        default: begin
          fin = 1'b1; set_res = 1'b1; res_val = RES_BADCMD; fin_rsp = RSP_ERR;
        end
      endcase
    end else if (media_done) begin
      fin = 1'b1; set_res = 1'b1; res_val = med_status;
      if (med_status != '0) begin
        set_lba = 1'b1; fin_rsp = RSP_ERR;
      end else begin
        fin_rsp = RSP_READ; fin_len = med_len;
      end
    end
    if (set_res && res_val != '0) raise = 1'b1;
  end

  logic [7:0] st_base, status_nx, error_nx;
  always_comb begin
    st_base   = accept ? (status | 8'h80) : status;
    status_nx = st_base;
    error_nx  = error;
    if (set_res) begin
      status_nx = (res_val != '0) ? 8'h51 : (st_base & 8'h7E);
      error_nx  = fold_err(res_val);
    end
    if (force_ready) status_nx = 8'h50;
    if (raw_err) begin
      status_nx = 8'h51;
      error_nx  = RES_BADFIELD[7:0];
    end
  end

  rsp_e rsp_q;
  fmt_e fmt_q;
  assign resp_type = rsp_q;
  assign med_fmt   = fmt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= 8'h50; error <= 8'h01; done <= 1'b0; irq <= 1'b0;
      rsp_q <= RSP_NONE; resp_len <= '0; src_q <= SRC_NONE; base_q <= '0;
      med_req <= 1'b0; med_lba <= '0; med_count <= '0; fmt_q <= FMT_M1;
    end else begin
      status <= status_nx;
      error  <= error_nx;
      done   <= fin;
      irq    <= raise;
      if (fin) begin
        rsp_q <= fin_rsp; resp_len <= fin_len; src_q <= fin_src; base_q <= fin_base;
      end
      if (go_media) begin
        med_req   <= 1'b1;
        med_lba   <= {pb[2], pb[3], pb[4]};
        med_count <= {pb[8], pb[9], pb[10]};
        fmt_q     <= dec_fmt;
      end else if (media_done) begin
        med_req <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    case (src_q)
      SRC_ID: rd_data = id_val;
      SRC_SENSE:
        for (int k = 0; k < SENSE_BYTES; k++)
          if (rd_addr == 5'(k)) rd_data = snap[k];
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/pkt_cmd_checker.sv
module pkt_cmd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        media_done,
  input logic        done,
  input logic [1:0]  resp_type,
  input logic [7:0]  status,
  input logic [7:0]  error,
  input logic [79:0] sense,
  input logic        irq,
  input logic        med_req,
  input logic        med_ack
);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_accept_reacts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (done || med_req));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (med_req && !med_ack) |=> med_req);

  assert_req_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    media_done |=> (!med_req && done));

  assert_err_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && resp_type == 2'd2) |-> status == 8'h51);

  assert_read_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && resp_type == 2'd1) |-> (status[7] == 1'b0 && status[0] == 1'b0
                                     && error == 8'h00 && sense[7:0] == 8'hF0));

  assert_irq_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
endmodule

bind pkt_cmd_decoder pkt_cmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .media_done(media_done),
  .done(done), .resp_type(resp_type), .status(status), .error(error),
  .sense(sense), .irq(irq), .med_req(med_req), .med_ack(med_ack)
);

// File: tb/test_pkt_cmd_decoder.sv
`timescale 1ns/1ps
module test_pkt_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [95:0] cmd_pkt = '0;
  logic        medium_present = 1'b0;
  logic        med_req, med_ack = 1'b0;
  logic [23:0] med_lba, med_count;
  logic [1:0]  med_fmt;
  logic [15:0] med_status = '0, med_len = '0;
  logic        done, irq;
  logic [1:0]  resp_type;
  logic [15:0] resp_len;
  logic [7:0]  status, error, rd_data;
  logic [79:0] sense;
  logic [4:0]  rd_addr = '0;

  int checks = 0, failures = 0;
  bit finished = 0;
  int ack_delay = 0;

  always #5 clk = ~clk;

  pkt_cmd_decoder i_pkt_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_pkt(cmd_pkt),
    .medium_present(medium_present), .med_req(med_req), .med_lba(med_lba),
    .med_count(med_count), .med_fmt(med_fmt), .med_ack(med_ack),
    .med_status(med_status), .med_len(med_len), .done(done),
    .resp_type(resp_type), .resp_len(resp_len), .irq(irq), .status(status),
    .error(error), .sense(sense), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_status, m_error, m_done, m_irq, m_rsp, m_len, m_src, m_base;
  int m_req, m_lba, m_cnt, m_fmt;
  int m_sense [10];
  int m_snap [10];

  function automatic int idtab(int k);
    return (37 * k + 11) % 256;
  endfunction

  task automatic m_post(input int r);
    m_sense[0] = 240;
    m_sense[2] = r % 256;
    m_sense[8] = r / 256;
    m_error = (r % 16) * 16;
    if (r != 0) begin m_status = 81; m_irq = 1; end
    else m_status = m_status - (m_status % 2) - ((m_status >= 128) ? 128 : 0);
  endtask

  task automatic m_finish(input int rsp, input int len, input int src, input int base);
    m_done = 1; m_rsp = rsp; m_len = len; m_src = src; m_base = base;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_status = 80; m_error = 1; m_done = 0; m_irq = 0; m_rsp = 0; m_len = 0;
      m_src = 0; m_base = 0; m_req = 0; m_lba = 0; m_cnt = 0; m_fmt = 0;
      for (int i = 0; i < 10; i++) begin m_sense[i] = 0; m_snap[i] = 0; end
    end else begin
      m_done = 0; m_irq = 0;
      if (m_req != 0 && med_ack) begin
        m_req = 0;
        m_post(int'(med_status));
        if (med_status != 0) begin
          m_sense[5] = (m_lba / 65536) % 256;
          m_sense[6] = (m_lba / 256) % 256;
          m_sense[7] = m_lba % 256;
          m_finish(2, 0, 0, 0);
        end else m_finish(1, int'(med_len), 0, 0);
      end else if (cmd_start && m_req == 0) begin
        int op, p1, p2, p4;
        op = int'(cmd_pkt[7:0]); p1 = int'(cmd_pkt[15:8]);
        p2 = int'(cmd_pkt[23:16]); p4 = int'(cmd_pkt[39:32]);
        if (m_status < 128) m_status = m_status + 128;
        if (op == 0) begin
          if (!medium_present) begin m_post(16'h3A02); m_finish(2, 0, 0, 0); end
          else begin m_post(0); m_status = 80; m_irq = 1; m_finish(0, 0, 0, 0); end
        end else if (op == 18) begin
          if (p2 >= 32) begin m_status = 81; m_error = 5; m_finish(2, 0, 0, 0); end
          else begin
            m_post(0);
            m_finish(1, (p4 > 32 - p2) ? 32 - p2 : p4, 1, p2);
          end
        end else if (op == 3) begin
          for (int i = 0; i < 10; i++) m_snap[i] = m_sense[i];
          m_post(0);
          m_finish(1, (p4 > 10) ? 10 : p4, 2, 0);
        end else if (op == 112) begin
          m_post(0); m_irq = 1; m_finish(0, 0, 0, 0);
        end else if (op == 48) begin
          if (p1 == 32 || p1 == 40 || p1 == 36 || p1 == 48) begin
            m_req = 1;
            m_fmt = (p1 == 36) ? 1 : (p1 == 48) ? 2 : 0;
            m_lba = int'({cmd_pkt[23:16], cmd_pkt[31:24], cmd_pkt[39:32]});
            m_cnt = int'({cmd_pkt[71:64], cmd_pkt[79:72], cmd_pkt[87:80]});
          end else begin m_post(16'h2405); m_finish(2, 0, 0, 0); end
        end else begin
          m_post(16'h2005); m_finish(2, 0, 0, 0);
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 status", int'(status), m_status);
      chk("R2 error", int'(error), m_error);
      for (int i = 0; i < 10; i++)
        chk("R2/R10 sense byte", int'(sense[8*i +: 8]), m_sense[i]);
      chk("R3 done", int'(done), m_done);
      chk("R2 irq", int'(irq), m_irq);
      chk("R10 med_req", int'(med_req), m_req);
      if (done) begin
        chk("R3 resp_type", int'(resp_type), m_rsp);
        chk("R3 resp_len", int'(resp_len), m_len);
      end
      if (med_req) begin
        chk("R8 med_lba", int'(med_lba), m_lba);
        chk("R8 med_count", int'(med_count), m_cnt);
        chk("R8 med_fmt", int'(med_fmt), m_fmt);
      end
    end
  end

  // media responder
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (med_ack) med_ack = 1'b0;
      else if (med_req) begin
        if (cnt >= ack_delay) begin med_ack = 1'b1; cnt = 0; end
        else cnt++;
      end
    end
  end

  function automatic logic [95:0] pk(input int op, input int m, input int b2, input int b3,
                                     input int b4, input int b8, input int b9, input int b10);
    logic [95:0] p = '0;
    p[7:0] = 8'(op); p[15:8] = 8'(m); p[23:16] = 8'(b2); p[31:24] = 8'(b3);
    p[39:32] = 8'(b4); p[71:64] = 8'(b8); p[79:72] = 8'(b9); p[87:80] = 8'(b10);
    return p;
  endfunction

  task automatic send(input logic [95:0] p, input string tag);
    int guard = 0;
    @(negedge clk);
    cmd_pkt = p; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    while (!done && guard < 100) begin @(negedge clk); guard++; end
    chk({tag, " completion seen"}, int'(done), 1);
    // response bytes through the read port
    for (int a = 0; a < 32; a++) begin
      int e;
      rd_addr = 5'(a);
      #1;
      if (m_src == 1) e = (m_base + a < 32) ? idtab(m_base + a) : 0;
      else if (m_src == 2) e = (a < 10) ? m_snap[a] : 0;
      else e = 0;
      chk({tag, " rd_data"}, int'(rd_data), e);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    chk("R1 status at reset", int'(status), 8'h50);
    chk("R1 error at reset", int'(error), 8'h01);
    chk("R1 sense at reset", (sense == '0) ? 1 : 0, 1);
    chk("R1 done low", int'(done), 0);
    chk("R1 med_req low", int'(med_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    medium_present = 1'b0;
    send(pk(8'h00, 0, 0, 0, 0, 0, 0, 0), "R4 no medium");
    send(pk(8'h03, 0, 0, 0, 4, 0, 0, 0), "R6 sense len 4");
    medium_present = 1'b1;
    send(pk(8'h00, 0, 0, 0, 0, 0, 0, 0), "R4 medium");
    send(pk(8'h03, 0, 0, 0, 20, 0, 0, 0), "R6 sense clipped");
    send(pk(8'h12, 0, 0, 0, 32, 0, 0, 0), "R5 identity full");
    send(pk(8'h12, 0, 28, 0, 10, 0, 0, 0), "R5 identity clipped");
    send(pk(8'h12, 0, 5, 0, 0, 0, 0, 0), "R5 identity zero length");
    send(pk(8'h12, 0, 32, 0, 4, 0, 0, 0), "R5 identity bad offset");
    send(pk(8'h70, 0, 0, 0, 0, 0, 0, 0), "R7 spin-up");
    med_status = 16'h0000; med_len = 16'd2048; ack_delay = 0;
    send(pk(8'h30, 8'h20, 8'h01, 8'h02, 8'h03, 0, 0, 1), "R8 mode-1 read");
    med_len = 16'd4096; ack_delay = 3;
    send(pk(8'h30, 8'h24, 8'hAB, 8'hCD, 8'hEF, 8'h00, 8'h01, 8'h02), "R8 extended read");
    med_len = 16'd2352; ack_delay = 1;
    send(pk(8'h30, 8'h30, 0, 0, 16, 0, 0, 3), "R8 raw read");
    send(pk(8'h30, 8'h28, 0, 1, 0, 0, 0, 8), "R8 alt mode-1 read");
    send(pk(8'h30, 8'h22, 0, 0, 0, 0, 0, 1), "R9 bad mode");
    med_status = 16'h1234; ack_delay = 5;
    send(pk(8'h30, 8'h20, 8'h12, 8'h34, 8'h56, 0, 0, 1), "R10 media failure");
    send(pk(8'h03, 0, 0, 0, 10, 0, 0, 0), "R6 sense after failure");
    med_status = 16'h0000;
    send(pk(8'h99, 0, 0, 0, 0, 0, 0, 0), "R11 unknown opcode");
    send(pk(8'h03, 0, 0, 0, 10, 0, 0, 0), "R11 sense after unknown");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule